// File: doc/BRIEF.md
# Supply Supervisor Reset and Watchdog Controller

This block is the digital heart of a processor supervisor. Comparator decisions arrive already digitized and synchronous to the block clock: the main rail below its primary trip point, a secondary monitor below its own trip point, and the backup battery above the main rail. From these, and from a raw manual-reset pin, a watchdog kick strobe and two 2-bit selection inputs, it derives the system reset, an early low-line warning, a secondary-fail flag, an active-low watchdog fault and the select line for the backup rail switch.

All timing counts a slow timebase. A prescaler divides the clock into a one-cycle tick every `TICK_DIV` clocks. The reset stretch, the manual-reset debounce and the watchdog each count those ticks. The four reset timeouts, the three watchdog intervals and the debounce length are parameters in ticks; the defaults give a 1 ms tick at 50 MHz. A parameter sets the reset polarity.

Top module: `supply_supervisor`

## Requirements
- R1: While `rst_n` is low the system reset is active. After `rst_n` rises it stays active for the timeout chosen by `hold_sel_i`.
- R2: `hold_sel_i` codes 0, 1, 2 and 3 select `HOLD_T0`, `HOLD_T1`, `HOLD_T2` and `HOLD_T3` ticks. Once the last hold cause clears, reset ends after more than (T-1)·`TICK_DIV` clocks and at most T·`TICK_DIV` clocks.
- R3: The system reset is active for as long as `vcc_low_i` is 1. After `vcc_low_i` returns to 0 the selected timeout follows.
- R4: A debounced low on `mr_n_i` asserts reset. Reset holds while the debounced pin stays low and for the selected timeout after the debounced release.
- R5: `mr_n_i` changes its debounced level only after it differs from the current level for `MR_STABLE` consecutive ticks. Low pulses of at most (`MR_STABLE`-2) tick periods, and bouncing whose low stretches are that short, produce no reset.
- R6: `lowline_n_o` equals the inverse of `vcc_low_i` in the same cycle. It is not stretched.
- R7: `aux_fail_n_o` equals the inverse of `aux_low_i` in the same cycle, including while `rst_n` is low and while reset is active.
- R8: `batt_sel_o` is 1 exactly when `vcc_low_i` and `batt_above_i` are both 1.
- R9: `wd_sel_i` codes 0, 1 and 2 select `WD_T0`, `WD_T1` and `WD_T2` ticks. With no kick, `wd_fault_n_o` goes low after more than (L-1)·`TICK_DIV` clocks and at most L·`TICK_DIV`+1 clocks. Code 3 disables the watchdog, and `wd_fault_n_o` then stays 1.
- R10: Once low, `wd_fault_n_o` stays low until a kick or an active system reset. Either one clears the fault by the next cycle and restarts the interval, so kicks spaced closer than (L-1) tick periods keep it high.
- R11: With `RESET_ACTIVE_HIGH` = 1, `sys_reset_o` is 1 when reset is active. With 0 it is 0 when reset is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset; starts the power-on timeout |
| vcc_low_i | input | 1 | Main rail below primary trip point |
| aux_low_i | input | 1 | Secondary monitor below its trip point |
| batt_above_i | input | 1 | Battery voltage above main rail |
| mr_n_i | input | 1 | Raw manual-reset pin, active low |
| wd_kick_i | input | 1 | Watchdog restart strobe |
| hold_sel_i | input | 2 | Reset timeout select |
| wd_sel_i | input | 2 | Watchdog interval select, 3 = off |
| sys_reset_o | output | 1 | System reset, polarity set by `RESET_ACTIVE_HIGH` |
| lowline_n_o | output | 1 | Early low-line warning, active low |
| aux_fail_n_o | output | 1 | Secondary-fail flag, active low |
| wd_fault_n_o | output | 1 | Watchdog fault, active low |
| batt_sel_o | output | 1 | Selects battery for the output rail |

## Verification
The bench builds two copies with `TICK_DIV` = 4, reset timeouts of 3, 5, 8 and 12 ticks, watchdog intervals of 6, 10 and 15 ticks, and the full 16-tick debounce. One copy has an active-high reset and the other an active-low reset. The short tick makes every timeout code, every watchdog code, and every phase of a release against the tick cheap to sweep. Each measured duration is compared against the window computed from the tick arithmetic. All eight combinations of the comparator flags are applied, and manual-reset glitches and bouncing sit just under the debounce length.

// File: rtl/sup_pkg.sv
// Shared types and elaboration helpers for the supply supervisor.
// Assumes: nothing beyond plain SystemVerilog; used at elaboration only.
package sup_pkg;

    // Watchdog interval selection; the last code turns the watchdog off.
    typedef enum logic [1:0] {
        WD_SEL_SHORT = 2'd0,
        WD_SEL_MID   = 2'd1,
        WD_SEL_LONG  = 2'd2,
        WD_SEL_OFF   = 2'd3
    } wd_sel_e;

    // Digitized comparator decisions for the supervised rails.
    typedef struct packed {
        logic main_low;
        logic aux_low;
        logic batt_high;
    } supply_flags_t;

    // Largest of four tick counts, used to size counters.
    function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    // Bits needed to hold values 0..v, never less than one.
    function automatic int unsigned width_for(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/sup_tick_gen.sv
// Timebase prescaler: emits a one-cycle tick every DIV clocks.
// Assumes: DIV >= 1; with DIV = 1 the tick is a registered copy of rst_n.
module sup_tick_gen #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    generate
        if (DIV <= 1) begin : g_every_clock
            logic tick_q;
            // Tick on every clock once out of reset.
            always_ff @(posedge clk) begin
                tick_q <= rst_n;
            end
            assign tick_o = tick_q;
        end else begin : g_divider
            localparam int unsigned CW = $clog2(DIV);
            logic [CW-1:0] phase_q;
            // Wrap-around phase counter of the prescaler.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    phase_q <= '0;
                end else if (phase_q == CW'(DIV - 1)) begin
                    phase_q <= '0;
                end else begin
                    phase_q <= phase_q + 1'b1;
                end
            end
            assign tick_o = (phase_q == CW'(DIV - 1));
        end
    endgenerate

endmodule

// File: rtl/sup_mr_debounce.sv
// Manual-reset conditioner: two-flop synchronizer followed by a tick-based
// debounce that accepts a new level only after STABLE_TICKS consecutive ticks
// on which the synchronized pin differed from the accepted level.
// Assumes: pin is active low and idles high; STABLE_TICKS >= 2.
module sup_mr_debounce #(
    parameter int unsigned STABLE_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic mr_n_i,
    output logic mr_active_o
);

    localparam int unsigned CW = sup_pkg::width_for(STABLE_TICKS - 1);

    logic [1:0]    sync_q;
    logic          level_q;
    logic [CW-1:0] run_q;
    logic          pin_s;

    assign pin_s = sync_q[1];

    // Bring the asynchronous pin into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
        end else begin
            sync_q <= {sync_q[0], mr_n_i};
        end
    end

    // Count ticks of disagreement; any agreeing cycle restarts the run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b1;
            run_q   <= '0;
        end else if (pin_s == level_q) begin
            run_q <= '0;
        end else if (tick_i) begin
            if (run_q == CW'(STABLE_TICKS - 1)) begin
                level_q <= pin_s;
                run_q   <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign mr_active_o = ~level_q;

    // R5: the accepted level only moves on a timebase tick.
    a_r5_accept_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (level_q != $past(level_q))) |-> $past(tick_i));

endmodule

// File: rtl/sup_reset_stretch.sv
// Reset generator: holds reset while a hold cause is present or rst_n is low,
// then keeps it for the selected number of ticks after the cause clears.
// Assumes: every timeout is at least one tick.
module sup_reset_stretch #(
    parameter int unsigned T0 = 50,
    parameter int unsigned T1 = 200,
    parameter int unsigned T2 = 400,
    parameter int unsigned T3 = 800
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       hold_i,
    input  logic [1:0] sel_i,
    output logic       in_reset_o
);

    localparam int unsigned TMAX = sup_pkg::max_of4(T0, T1, T2, T3);
    localparam int unsigned CW   = sup_pkg::width_for(TMAX);

    logic [CW-1:0] span;
    logic [CW-1:0] left_q;

    // Translate the select code into a tick count.
    always_comb begin
        case (sel_i)
            2'd0:    span = CW'(T0);
            2'd1:    span = CW'(T1);
            2'd2:    span = CW'(T2);
            default: span = CW'(T3);
        endcase
    end

    // Reload while held, then count remaining ticks down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_i) begin
            left_q <= span;
        end else if (tick_i && (left_q != '0)) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign in_reset_o = hold_i | (left_q != '0);

    // R2: reset is released only by a tick after the hold cause is gone.
    a_r2_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(in_reset_o)) |-> ($past(tick_i) && !$past(hold_i)));

    // R3: with no hold cause the remaining time never grows.
    a_r3_countdown_only: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !hold_i && !$past(hold_i)) |-> (left_q <= $past(left_q)));

endmodule

// File: rtl/sup_watchdog.sv
// Watchdog: counts ticks since the last kick and raises a sticky fault when
// the selected interval elapses; kick, active reset or the off code clear it.
// Assumes: every interval is at least one tick.
module sup_watchdog #(
    parameter int unsigned L0 = 25,
    parameter int unsigned L1 = 200,
    parameter int unsigned L2 = 1400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             clear_i,
    input  logic             kick_i,
    input  sup_pkg::wd_sel_e sel_i,
    output logic             fault_o
);

    localparam int unsigned LMAX = sup_pkg::max_of4(L0, L1, L2, 1);
    localparam int unsigned CW   = sup_pkg::width_for(LMAX);

    logic [CW-1:0] last_tick;
    logic [CW-1:0] age_q;
    logic          fault_q;

    // Index of the tick that completes the chosen interval.
    always_comb begin
        case (sel_i)
            sup_pkg::WD_SEL_SHORT: last_tick = CW'(L0 - 1);
            sup_pkg::WD_SEL_MID:   last_tick = CW'(L1 - 1);
            sup_pkg::WD_SEL_LONG:  last_tick = CW'(L2 - 1);
            default:               last_tick = '0;
        endcase
    end

    // Age the timer on ticks and latch the fault when it expires.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i || kick_i || (sel_i == sup_pkg::WD_SEL_OFF)) begin
            age_q   <= '0;
            fault_q <= 1'b0;
        end else if (tick_i && !fault_q) begin
            if (age_q == last_tick) begin
                fault_q <= 1'b1;
            end else begin
                age_q <= age_q + 1'b1;
            end
        end
    end

    assign fault_o = fault_q;

    // R9: a fault appears only on a tick with the watchdog enabled.
    a_r9_fault_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(fault_q)) |->
            ($past(tick_i) && ($past(sel_i) != sup_pkg::WD_SEL_OFF)));

    // R10: a kick clears the fault by the next cycle.
    a_r10_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
        kick_i |=> !fault_q);

    // R10: with nothing to clear it, a fault persists.
    a_r10_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q && !kick_i && !clear_i && (sel_i != sup_pkg::WD_SEL_OFF)) |=> fault_q);

endmodule

// File: rtl/supply_supervisor.sv
// Supply supervisor top: combines the timebase, manual-reset debounce,
// reset stretch and watchdog, and drives the direct supply status outputs.
// Assumes: comparator flags are already synchronous to clk; timing
// parameters are in ticks of TICK_DIV clocks.
module supply_supervisor #(
    parameter int unsigned TICK_DIV          = 50000,
    parameter int unsigned HOLD_T0           = 50,
    parameter int unsigned HOLD_T1           = 200,
    parameter int unsigned HOLD_T2           = 400,
    parameter int unsigned HOLD_T3           = 800,
    parameter int unsigned WD_T0             = 25,
    parameter int unsigned WD_T1             = 200,
    parameter int unsigned WD_T2             = 1400,
    parameter int unsigned MR_STABLE         = 16,
    parameter bit          RESET_ACTIVE_HIGH = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vcc_low_i,
    input  logic       aux_low_i,
    input  logic       batt_above_i,
    input  logic       mr_n_i,
    input  logic       wd_kick_i,
    input  logic [1:0] hold_sel_i,
    input  logic [1:0] wd_sel_i,
    output logic       sys_reset_o,
    output logic       lowline_n_o,
    output logic       aux_fail_n_o,
    output logic       wd_fault_n_o,
    output logic       batt_sel_o
);

    sup_pkg::supply_flags_t flags;
    logic                   tick;
    logic                   mr_active;
    logic                   in_reset;
    logic                   wd_fault;

    assign flags = '{main_low: vcc_low_i, aux_low: aux_low_i, batt_high: batt_above_i};

    sup_tick_gen #(
        .DIV (TICK_DIV)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    sup_mr_debounce #(
        .STABLE_TICKS (MR_STABLE)
    ) u_mr (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .mr_n_i      (mr_n_i),
        .mr_active_o (mr_active)
    );

    sup_reset_stretch #(
        .T0 (HOLD_T0),
        .T1 (HOLD_T1),
        .T2 (HOLD_T2),
        .T3 (HOLD_T3)
    ) u_stretch (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .hold_i     (flags.main_low | mr_active),
        .sel_i      (hold_sel_i),
        .in_reset_o (in_reset)
    );

    sup_watchdog #(
        .L0 (WD_T0),
        .L1 (WD_T1),
        .L2 (WD_T2)
    ) u_wd (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .clear_i (in_reset),
        .kick_i  (wd_kick_i),
        .sel_i   (sup_pkg::wd_sel_e'(wd_sel_i)),
        .fault_o (wd_fault)
    );

    // Reset polarity variant chosen at elaboration.
    generate
        if (RESET_ACTIVE_HIGH) begin : g_rst_high
            assign sys_reset_o = in_reset;
        end else begin : g_rst_low
            assign sys_reset_o = ~in_reset;
        end
    endgenerate

    // Undelayed status outputs and rail switch select.
    assign lowline_n_o  = ~flags.main_low;
    assign aux_fail_n_o = ~flags.aux_low;
    assign wd_fault_n_o = ~wd_fault;
    assign batt_sel_o   = flags.main_low & flags.batt_high;

    // R10: an active system reset clears the watchdog fault by the next cycle.
    a_r10_reset_clears_fault: assert property (@(posedge clk) disable iff (!rst_n)
        in_reset |=> wd_fault_n_o);

endmodule

// File: tb/supply_supervisor_bench.sv
// Bench for the supply supervisor: two polarity variants, short tick.
module supply_supervisor_bench;

    localparam int DIV = 4;
    localparam int DEB = 16;
    localparam int LIMIT = 3000;

    function automatic int hold_t(input int s);
        case (s)
            0: return 3;
            1: return 5;
            2: return 8;
            default: return 12;
        endcase
    endfunction

    function automatic int wd_t(input int s);
        case (s)
            0: return 6;
            1: return 10;
            default: return 15;
        endcase
    endfunction

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vcc_low = 1'b0;
    logic       aux_low = 1'b0;
    logic       batt_hi = 1'b0;
    logic       mr_n = 1'b1;
    logic       kick = 1'b0;
    logic [1:0] hold_sel = 2'd0;
    logic [1:0] wd_sel = 2'd3;

    logic rst_hi, lowline_n, aux_fail_n, wdo_n, batt_sel;
    logic rst_lo, lo_lowline_n, lo_aux_fail_n, lo_wdo_n, lo_batt_sel;

    int n_total = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    supply_supervisor #(
        .TICK_DIV(DIV), .HOLD_T0(3), .HOLD_T1(5), .HOLD_T2(8), .HOLD_T3(12),
        .WD_T0(6), .WD_T1(10), .WD_T2(15), .MR_STABLE(DEB), .RESET_ACTIVE_HIGH(1'b1)
    ) u_supply_supervisor (
        .clk(clk), .rst_n(rst_n), .vcc_low_i(vcc_low), .aux_low_i(aux_low),
        .batt_above_i(batt_hi), .mr_n_i(mr_n), .wd_kick_i(kick),
        .hold_sel_i(hold_sel), .wd_sel_i(wd_sel), .sys_reset_o(rst_hi),
        .lowline_n_o(lowline_n), .aux_fail_n_o(aux_fail_n),
        .wd_fault_n_o(wdo_n), .batt_sel_o(batt_sel)
    );

    supply_supervisor #(
        .TICK_DIV(DIV), .HOLD_T0(3), .HOLD_T1(5), .HOLD_T2(8), .HOLD_T3(12),
        .WD_T0(6), .WD_T1(10), .WD_T2(15), .MR_STABLE(DEB), .RESET_ACTIVE_HIGH(1'b0)
    ) u_supply_supervisor_lo (
        .clk(clk), .rst_n(rst_n), .vcc_low_i(vcc_low), .aux_low_i(aux_low),
        .batt_above_i(batt_hi), .mr_n_i(mr_n), .wd_kick_i(kick),
        .hold_sel_i(hold_sel), .wd_sel_i(wd_sel), .sys_reset_o(rst_lo),
        .lowline_n_o(lo_lowline_n), .aux_fail_n_o(lo_aux_fail_n),
        .wd_fault_n_o(lo_wdo_n), .batt_sel_o(lo_batt_sel)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input string what,
                           input int act, input int lo, input int hi);
        n_total++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
        end
    endtask

    // Clocks until the active-high reset drops.
    task automatic time_release(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (rst_hi && n < LIMIT);
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        while (rst_hi && n < LIMIT) begin
            @(negedge clk);
            n++;
        end
    endtask

    // Hung-run guard.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        n_total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        int n;
        bit seen;
        // R1 / R7 / R11: state while rst_n is low.
        aux_low = 1'b1;
        repeat (3) @(negedge clk);
        chk(rst_hi == 1'b1, "R1", "reset active in block reset", rst_hi, 1);
        chk(rst_lo == 1'b0, "R11", "low-polarity variant asserted", rst_lo, 0);
        chk(aux_fail_n == 1'b0, "R7", "aux flag during block reset", aux_fail_n, 0);
        chk(wdo_n == 1'b1, "R9", "no fault in reset", wdo_n, 1);
        aux_low = 1'b0;

        // R1 / R2: power-on timeout for every code.
        for (int s = 0; s < 4; s++) begin
            rst_n = 1'b0;
            hold_sel = 2'(s);
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            time_release(n);
            chk_rng("R1", "power-on stretch", n, (hold_t(s) - 1) * DIV + 1, hold_t(s) * DIV);
            chk(rst_lo == 1'b1, "R11", "low-polarity variant released", rst_lo, 1);
        end

        // R2 / R3: main-supply hold, every code and every tick phase.
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < DIV; p++) begin
                hold_sel = 2'(s);
                vcc_low = 1'b1;
                repeat (5 + p) @(negedge clk);
                chk(rst_hi == 1'b1, "R3", "reset while rail low", rst_hi, 1);
                chk(lowline_n == 1'b0, "R6", "lowline while rail low", lowline_n, 0);
                vcc_low = 1'b0;
                #1;
                chk(lowline_n == 1'b1, "R6", "lowline not stretched", lowline_n, 1);
                time_release(n);
                chk_rng("R2", "rail-return stretch", n, (hold_t(s) - 1) * DIV + 1, hold_t(s) * DIV);
            end
        end

        // R6 / R7 / R8: all flag combinations.
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            vcc_low = c[0];
            aux_low = c[1];
            batt_hi = c[2];
            #1;
            chk(lowline_n == !c[0], "R6", "lowline follows rail", lowline_n, !c[0]);
            chk(aux_fail_n == !c[1], "R7", "aux fail follows monitor", aux_fail_n, !c[1]);
            chk(batt_sel == (c[0] && c[2]), "R8", "battery select", batt_sel, c[0] && c[2]);
        end
        @(negedge clk);
        vcc_low = 1'b0;
        aux_low = 1'b0;
        batt_hi = 1'b0;
        wait_idle();

        // R4: manual reset assert, hold, release.
        hold_sel = 2'd1;
        @(negedge clk);
        mr_n = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!rst_hi && n < LIMIT);
        chk_rng("R4", "manual reset assert delay", n, (DEB - 1) * DIV + 1, DEB * DIV + 3);
        repeat (20) @(negedge clk);
        chk(rst_hi == 1'b1, "R4", "reset held while pin low", rst_hi, 1);
        mr_n = 1'b1;
        time_release(n);
        chk_rng("R4", "manual release stretch", n, (DEB - 1 + 5) * DIV + 1, (DEB + 5) * DIV + 3);

        // R5: short glitch ignored.
        @(negedge clk);
        seen = 1'b0;
        mr_n = 1'b0;
        for (int i = 0; i < (DEB - 2) * DIV; i++) begin
            @(negedge clk);
            if (rst_hi) seen = 1'b1;
        end
        mr_n = 1'b1;
        for (int i = 0; i < 2 * DEB * DIV; i++) begin
            @(negedge clk);
            if (rst_hi) seen = 1'b1;
        end
        chk(seen == 1'b0, "R5", "short low pulse ignored", seen, 0);

        // R5: bouncing pin ignored.
        seen = 1'b0;
        for (int b = 0; b < 6; b++) begin
            mr_n = 1'b0;
            for (int i = 0; i < 3 * DIV; i++) begin
                @(negedge clk);
                if (rst_hi) seen = 1'b1;
            end
            mr_n = 1'b1;
            for (int i = 0; i < DIV; i++) begin
                @(negedge clk);
                if (rst_hi) seen = 1'b1;
            end
        end
        for (int i = 0; i < 2 * DEB * DIV; i++) begin
            @(negedge clk);
            if (rst_hi) seen = 1'b1;
        end
        chk(seen == 1'b0, "R5", "bouncing pin ignored", seen, 0);

        // R9 / R10: each watchdog interval, stickiness, kick clear.
        for (int s = 0; s < 3; s++) begin
            wd_sel = 2'(s);
            kick = 1'b1;
            @(negedge clk);
            kick = 1'b0;
            n = 1;
            chk(wdo_n == 1'b1, "R10", "no fault right after kick", wdo_n, 1);
            while (wdo_n && n < LIMIT) begin
                @(negedge clk);
                n++;
            end
            chk_rng("R9", "watchdog interval", n, (wd_t(s) - 1) * DIV + 1, wd_t(s) * DIV + 1);
            repeat (3 * wd_t(s) * DIV) @(negedge clk);
            chk(wdo_n == 1'b0, "R10", "fault sticky", wdo_n, 0);
            kick = 1'b1;
            @(negedge clk);
            kick = 1'b0;
            chk(wdo_n == 1'b1, "R10", "kick clears fault", wdo_n, 1);
        end

        // R10: regular kicks keep the fault away.
        wd_sel = 2'd1;
        seen = 1'b0;
        for (int k = 0; k < 6; k++) begin
            kick = 1'b1;
            @(negedge clk);
            kick = 1'b0;
            for (int i = 0; i < (wd_t(1) - 2) * DIV; i++) begin
                @(negedge clk);
                if (!wdo_n) seen = 1'b1;
            end
        end
        chk(seen == 1'b0, "R10", "periodic kicks prevent fault", seen, 0);

        // R10: system reset clears a fault.
        wd_sel = 2'd0;
        n = 0;
        while (wdo_n && n < LIMIT) begin
            @(negedge clk);
            n++;
        end
        chk(wdo_n == 1'b0, "R9", "fault before reset test", wdo_n, 0);
        vcc_low = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(wdo_n == 1'b1, "R10", "reset clears fault", wdo_n, 1);
        vcc_low = 1'b0;
        wait_idle();

        // R9: off code never faults.
        wd_sel = 2'd3;
        seen = 1'b0;
        for (int i = 0; i < 3 * 15 * DIV; i++) begin
            @(negedge clk);
            if (!wdo_n) seen = 1'b1;
        end
        chk(seen == 1'b0, "R9", "watchdog off", seen, 0);

        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule